// File: doc/BRIEF.md
# Radio Power-State Controller

This block decides which power mode a short-range frequency-hopping transceiver is in, and drives the enables that follow from that mode. It produces the on/off controls for the reference oscillator, the gated clock sent to the baseband, the frequency synthesizer, the transmit and receive chains, and the modem. Its inputs are register-derived commands (a channel write, transmit and receive request bits, a burst-stop command and a power-down bit) together with the external transmit and receive enable pins. A mode input selects which of the two families of inputs starts and ends a burst.

In the pin-driven (unidirectional) mode, a rising pin starts a burst and a falling pin ends it. In the register-driven (bidirectional) mode, the request bits start a burst and only an explicit stop command ends it. Synthesizer lock and oscillator restart are modelled as programmable cycle counts, `LOCK_CYCLES` and `OSC_SETTLE`. The output clock is switched only while the system clock is low, so it never carries a shortened pulse.

Top module: `rf_power_ctrl`

## Requirements
- R1: An active-low `rstN` (asynchronous) or a `softRst` pulse (taking effect at the next clock edge) puts the controller in IDLE. In IDLE `refClkEn` is 1, `clkOut` follows `clk`, and `synthEn`, `txEn`, `rxEn`, `modemEn` and `synthLocked` are 0. `stateOh` is one-hot with bit 0 = SLEEP, bit 1 = IDLE, bit 2 = VCO_ACTIVE, bit 3 = TX_ACTIVE and bit 4 = RX_ACTIVE.
- R2: A `hopSet` pulse in IDLE moves the controller to VCO_ACTIVE at the next edge, with `synthEn` = 1. A `hopSet` pulse in SLEEP, TX_ACTIVE or RX_ACTIVE does not change the state.
- R3: `synthLocked` goes to 1 exactly `LOCK_CYCLES` clock edges after the edge that takes a `hopSet` pulse. A further `hopSet` in VCO_ACTIVE clears it and restarts the count.
- R4: In VCO_ACTIVE, a rising transmit source moves the controller to TX_ACTIVE (`synthEn`, `txEn` and `modemEn` are 1). A rising receive source moves it to RX_ACTIVE (`synthEn`, `rxEn` and `modemEn` are 1).
- R5: If the transmit and receive sources rise in the same cycle in VCO_ACTIVE, the controller enters TX_ACTIVE.
- R6: With `modeBidir` = 0, the pins are the sources. A falling `txPin` in TX_ACTIVE, or a falling `rxPin` in RX_ACTIVE, returns the controller to IDLE at the next edge. `txBit`, `rxBit` and `burstStop` have no effect in this mode.
- R7: With `modeBidir` = 1, `txBit` and `rxBit` are the sources and the pins have no effect. A falling request bit does not end a burst; a `burstStop` pulse returns TX_ACTIVE or RX_ACTIVE to IDLE.
- R8: `pdWrite` with `pdValue` = 1 in IDLE enters SLEEP at the next edge. In SLEEP, `refClkEn`, `synthEn` and `modemEn` are 0, and `clkOut` stays low from the next falling clock edge on.
- R9: `pdWrite` with `pdValue` = 1 in VCO_ACTIVE, TX_ACTIVE or RX_ACTIVE first moves to IDLE with all RF enables off. The controller enters SLEEP one edge later.
- R10: `pdWrite` with `pdValue` = 0 in SLEEP moves to IDLE with `refClkEn` = 1 at once. `clkOut` stays low for the next `OSC_SETTLE` rising edges and pulses again from the edge after those. The same write in any other state has no effect.
- R11: `stateOh` always has exactly one bit set, and `txEn` and `rxEn` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softRst | input | 1 | Register-issued reset pulse |
| modeBidir | input | 1 | 0: pins control bursts, 1: register bits control bursts |
| txPin | input | 1 | External transmit enable |
| rxPin | input | 1 | External receive enable |
| txBit | input | 1 | Register transmit request level |
| rxBit | input | 1 | Register receive request level |
| burstStop | input | 1 | Register command pulse ending a burst (bidirectional mode) |
| hopSet | input | 1 | Pulse marking a write of the channel field |
| pdWrite | input | 1 | Pulse marking a write of the power-down bit |
| pdValue | input | 1 | Value written to the power-down bit |
| stateOh | output | 5 | One-hot power state |
| refClkEn | output | 1 | Reference oscillator enable |
| clkOut | output | 1 | Glitch-free gated clock to the baseband |
| synthEn | output | 1 | Synthesizer enable |
| synthLocked | output | 1 | Modelled synthesizer lock |
| txEn | output | 1 | Transmit chain enable |
| rxEn | output | 1 | Receive chain enable |
| modemEn | output | 1 | Modem enable |

## Verification
The state sequence is first driven with pin-controlled bursts: separate transmit and receive bursts, and a burst in which both pins rise in the same cycle. These runs separate the two start paths, the transmit priority and the pin-fall exit. The same sequences are then repeated in the register-controlled mode with the pins toggling as a distraction. This shows that the source mux really switches, and that a falling request bit, unlike a falling pin, leaves the burst running. Power-down is issued from IDLE and from an active burst to tell the direct path from the one that passes through IDLE. The lock and oscillator-restart counts are checked edge by edge, so that an off-by-one in either count is caught.

// File: rtl/rf_power_pkg.sv
package rf_power_pkg;

  localparam int NUM_STATES = 5;

  typedef enum logic [2:0] {
    PS_SLEEP = 3'd0,
    PS_IDLE  = 3'd1,
    PS_VCO   = 3'd2,
    PS_TX    = 3'd3,
    PS_RX    = 3'd4
  } pwrState_e;

  // burst start/stop events from the datapath to the control
  typedef struct packed {
    logic txStart;
    logic rxStart;
    logic txEnd;
    logic rxEnd;
  } burstEvt_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic loadLock;
    logic loadWake;
  } dpStrobe_t;

endpackage

// File: rtl/rf_power_ctrl_fsm.sv
module rf_power_ctrl_fsm
  import rf_power_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      softRst,
  input  logic      hopSet,
  input  logic      pdWrite,
  input  logic      pdValue,
  input  burstEvt_t evt,
  output pwrState_e state,
  output dpStrobe_t strobe
);

  pwrState_e stateNext;
  logic      pdPend;
  logic      pdPendNext;
  logic      pdCmd;
  logic      puCmd;

  assign pdCmd = pdWrite & pdValue;
  assign puCmd = pdWrite & ~pdValue;

  always_comb begin
    stateNext  = state;
    pdPendNext = pdPend;
    strobe     = '0;
    unique case (state)
      PS_SLEEP: begin
        if (puCmd) begin
          stateNext       = PS_IDLE;
          strobe.loadWake = 1'b1;
        end
      end
      PS_IDLE: begin
        if (pdCmd || pdPend) begin
          stateNext  = PS_SLEEP;
          pdPendNext = 1'b0;
        end else if (hopSet) begin
          stateNext       = PS_VCO;
          strobe.loadLock = 1'b1;
        end
      end
      PS_VCO: begin
        if (pdCmd) begin
          stateNext  = PS_IDLE;
          pdPendNext = 1'b1;
        end else if (evt.txStart) begin
          stateNext = PS_TX;
        end else if (evt.rxStart) begin
          stateNext = PS_RX;
        end else if (hopSet) begin
          strobe.loadLock = 1'b1;
        end
      end
      PS_TX: begin
        if (pdCmd) begin
          stateNext  = PS_IDLE;
          pdPendNext = 1'b1;
        end else if (evt.txEnd) begin
          stateNext = PS_IDLE;
        end
      end
      PS_RX: begin
        if (pdCmd) begin
          stateNext  = PS_IDLE;
          pdPendNext = 1'b1;
        end else if (evt.rxEnd) begin
          stateNext = PS_IDLE;
        end
      end
      default: begin
        stateNext  = PS_IDLE;
        pdPendNext = 1'b0;
      end
    endcase
    if (softRst) begin
      stateNext  = PS_IDLE;
      pdPendNext = 1'b0;
      strobe     = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= PS_IDLE;
      pdPend <= 1'b0;
    end else begin
      state  <= stateNext;
      pdPend <= pdPendNext;
    end
  end

endmodule

// File: rtl/rf_power_ctrl_dp.sv
module rf_power_ctrl_dp
  import rf_power_pkg::*;
#(
  parameter int LOCK_CYCLES = 16,
  parameter int OSC_SETTLE  = 8
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  softRst,
  input  logic                  modeBidir,
  input  logic                  txPin,
  input  logic                  rxPin,
  input  logic                  txBit,
  input  logic                  rxBit,
  input  logic                  burstStop,
  input  pwrState_e             state,
  input  dpStrobe_t             strobe,
  output burstEvt_t             evt,
  output logic [NUM_STATES-1:0] stateOh,
  output logic                  refClkEn,
  output logic                  synthEn,
  output logic                  synthLocked,
  output logic                  txEn,
  output logic                  rxEn,
  output logic                  modemEn,
  output logic                  clkOut
);

  localparam int LANES  = 2;
  localparam int LOCK_W = $clog2(LOCK_CYCLES + 1);
  localparam int WAKE_W = $clog2(OSC_SETTLE + 1);
  localparam logic [LOCK_W-1:0] LOCK_LOAD = LOCK_W'(LOCK_CYCLES);
  localparam logic [WAKE_W-1:0] WAKE_LOAD = WAKE_W'(OSC_SETTLE);

  // lane 0 = transmit, lane 1 = receive
  logic [LANES-1:0] srcLvl;
  logic [LANES-1:0] riseLvl;
  logic [LANES-1:0] laneStop;

  assign srcLvl = modeBidir ? {rxBit, txBit} : {rxPin, txPin};

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic lastQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        lastQ <= 1'b0;
        else if (softRst) lastQ <= 1'b0;
        else              lastQ <= srcLvl[g];
      end
      assign riseLvl[g]  = srcLvl[g] & ~lastQ;
      assign laneStop[g] = modeBidir ? burstStop : (~srcLvl[g] & lastQ);
    end
  endgenerate

  assign evt = '{txStart: riseLvl[0], rxStart: riseLvl[1],
                 txEnd: laneStop[0], rxEnd: laneStop[1]};

  // modelled synthesizer lock time
  logic [LOCK_W-1:0] lockCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lockCnt <= '0;
    else if (softRst)         lockCnt <= '0;
    else if (strobe.loadLock) lockCnt <= LOCK_LOAD;
    else if (lockCnt != '0)   lockCnt <= lockCnt - 1'b1;
  end

  // modelled oscillator restart time
  logic [WAKE_W-1:0] wakeCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                wakeCnt <= '0;
    else if (softRst)         wakeCnt <= '0;
    else if (strobe.loadWake) wakeCnt <= WAKE_LOAD;
    else if (wakeCnt != '0)   wakeCnt <= wakeCnt - 1'b1;
  end

  generate
    for (genvar s = 0; s < NUM_STATES; s++) begin : g_onehot
      assign stateOh[s] = (state == 3'(s));
    end
  endgenerate

  assign refClkEn    = (state != PS_SLEEP);
  assign synthEn     = (state == PS_VCO) || (state == PS_TX) || (state == PS_RX);
  assign txEn        = (state == PS_TX);
  assign rxEn        = (state == PS_RX);
  assign modemEn     = txEn | rxEn;
  assign synthLocked = synthEn && (lockCnt == '0);

  // gate enable changes only while clk is low
  logic gateReq;
  logic gateQ;
  assign gateReq = refClkEn && (wakeCnt == '0);

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) gateQ <= 1'b1;
    else       gateQ <= gateReq;
  end

  assign clkOut = clk & gateQ;

endmodule

// File: rtl/rf_power_ctrl.sv
module rf_power_ctrl
  import rf_power_pkg::*;
#(
  parameter int LOCK_CYCLES = 16,
  parameter int OSC_SETTLE  = 8
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       softRst,
  input  logic       modeBidir,
  input  logic       txPin,
  input  logic       rxPin,
  input  logic       txBit,
  input  logic       rxBit,
  input  logic       burstStop,
  input  logic       hopSet,
  input  logic       pdWrite,
  input  logic       pdValue,
  output logic [4:0] stateOh,
  output logic       refClkEn,
  output logic       clkOut,
  output logic       synthEn,
  output logic       synthLocked,
  output logic       txEn,
  output logic       rxEn,
  output logic       modemEn
);

  pwrState_e state;
  dpStrobe_t strobe;
  burstEvt_t evt;

  rf_power_ctrl_fsm u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .softRst (softRst),
    .hopSet  (hopSet),
    .pdWrite (pdWrite),
    .pdValue (pdValue),
    .evt     (evt),
    .state   (state),
    .strobe  (strobe)
  );

  rf_power_ctrl_dp #(
    .LOCK_CYCLES (LOCK_CYCLES),
    .OSC_SETTLE  (OSC_SETTLE)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .softRst     (softRst),
    .modeBidir   (modeBidir),
    .txPin       (txPin),
    .rxPin       (rxPin),
    .txBit       (txBit),
    .rxBit       (rxBit),
    .burstStop   (burstStop),
    .state       (state),
    .strobe      (strobe),
    .evt         (evt),
    .stateOh     (stateOh),
    .refClkEn    (refClkEn),
    .synthEn     (synthEn),
    .synthLocked (synthLocked),
    .txEn        (txEn),
    .rxEn        (rxEn),
    .modemEn     (modemEn),
    .clkOut      (clkOut)
  );

endmodule

// File: rtl/rf_power_ctrl_chk.sv
module rf_power_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       softRst,
  input logic       modeBidir,
  input logic       txPin,
  input logic       burstStop,
  input logic       pdWrite,
  input logic       pdValue,
  input logic [4:0] stateOh,
  input logic       refClkEn,
  input logic       synthEn,
  input logic       synthLocked,
  input logic       txEn,
  input logic       rxEn,
  input logic       modemEn
);

  // R1
  soft_reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (stateOh == 5'b00010) && !synthEn && !modemEn);

  // R11
  one_hot_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(stateOh) == 1);

  // R11
  tx_rx_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(txEn && rxEn));

  // R8
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateOh[0] |-> !refClkEn && !synthEn && !modemEn);

  // R9
  pd_via_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateOh[3] || stateOh[4]) && pdWrite && pdValue && !softRst
      |=> stateOh[1] && !txEn && !rxEn);

  // R7
  bidir_hold_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateOh[3] && modeBidir && !burstStop && !pdWrite && !softRst |=> stateOh[3]);

  // R6
  unidir_fall_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateOh[3] && !modeBidir && $stable(modeBidir) && $fell(txPin) && !pdWrite && !softRst
      |=> stateOh[1]);

  // R10
  wake_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateOh[0] && pdWrite && !pdValue && !softRst |=> stateOh[1] && refClkEn);

  // R3
  locked_needs_synth_chk: assert property (@(posedge clk) disable iff (!rstN)
    synthLocked |-> synthEn);

endmodule

bind rf_power_ctrl rf_power_ctrl_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .softRst     (softRst),
  .modeBidir   (modeBidir),
  .txPin       (txPin),
  .burstStop   (burstStop),
  .pdWrite     (pdWrite),
  .pdValue     (pdValue),
  .stateOh     (stateOh),
  .refClkEn    (refClkEn),
  .synthEn     (synthEn),
  .synthLocked (synthLocked),
  .txEn        (txEn),
  .rxEn        (rxEn),
  .modemEn     (modemEn)
);

// File: tb/rf_power_ctrl_bench.sv
module rf_power_ctrl_bench;

  localparam int LOCK   = 6;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, softRst, modeBidir, txPin, rxPin, txBit, rxBit, burstStop;
  logic hopSet, pdWrite, pdValue;
  logic [4:0] stateOh;
  logic refClkEn, clkOut, synthEn, synthLocked, txEn, rxEn, modemEn;

  rf_power_ctrl #(.LOCK_CYCLES(LOCK), .OSC_SETTLE(SETTLE)) u_rf_power_ctrl (
    .clk(clk), .rstN(rstN), .softRst(softRst), .modeBidir(modeBidir),
    .txPin(txPin), .rxPin(rxPin), .txBit(txBit), .rxBit(rxBit),
    .burstStop(burstStop), .hopSet(hopSet), .pdWrite(pdWrite), .pdValue(pdValue),
    .stateOh(stateOh), .refClkEn(refClkEn), .clkOut(clkOut), .synthEn(synthEn),
    .synthLocked(synthLocked), .txEn(txEn), .rxEn(rxEn), .modemEn(modemEn)
  );

  wire [7:0] obsV = {stateOh, synthEn, txEn, rxEn};

  localparam logic [4:0] ST_S = 5'b00001, ST_I = 5'b00010, ST_V = 5'b00100,
                         ST_T = 5'b01000, ST_R = 5'b10000;

  typedef struct packed {
    logic mode, txP, rxP, txB, rxB, hop, stop, pdW, pdV;
    logic [4:0] st;
    logic sy, tx, rx;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    // mode txP rxP txB rxB hop stop pdW pdV  state synth tx rx req
    '{0,0,0,0,0,0,0,0,0, ST_I,0,0,0, 1},   // R1
    '{0,0,0,0,0,1,0,0,0, ST_V,1,0,0, 2},   // R2
    '{0,1,0,0,0,0,0,0,0, ST_T,1,1,0, 4},   // R4
    '{0,1,0,0,1,0,1,0,0, ST_T,1,1,0, 6},   // R6 bits and stop ignored
    '{0,0,0,0,0,0,0,0,0, ST_I,0,0,0, 6},   // R6 pin fall
    '{0,0,0,0,0,1,0,0,0, ST_V,1,0,0, 2},   // R2
    '{0,0,1,0,0,0,0,0,0, ST_R,1,0,1, 4},   // R4
    '{0,0,0,0,0,0,0,0,0, ST_I,0,0,0, 6},   // R6
    '{0,0,0,0,0,1,0,0,0, ST_V,1,0,0, 2},   // R2
    '{0,1,1,0,0,0,0,0,0, ST_T,1,1,0, 5},   // R5
    '{0,0,0,0,0,0,0,0,0, ST_I,0,0,0, 6},   // R6
    '{1,0,0,0,0,1,0,0,0, ST_V,1,0,0, 7},   // R7
    '{1,1,0,0,0,0,0,0,0, ST_V,1,0,0, 7},   // R7 pin ignored
    '{1,1,0,1,0,0,0,0,0, ST_T,1,1,0, 7},   // R7
    '{1,0,0,0,0,0,0,0,0, ST_T,1,1,0, 7},   // R7 bit fall keeps burst
    '{1,0,0,0,0,0,1,0,0, ST_I,0,0,0, 7},   // R7 stop
    '{1,0,0,0,0,1,0,0,0, ST_V,1,0,0, 7},   // R7
    '{1,0,0,0,1,0,0,0,0, ST_R,1,0,1, 7},   // R7
    '{1,0,0,0,1,0,1,0,0, ST_I,0,0,0, 7},   // R7
    '{1,0,0,0,0,0,0,0,0, ST_I,0,0,0, 7},   // R7
    '{0,0,0,0,0,0,0,1,1, ST_S,0,0,0, 8},   // R8
    '{0,0,0,0,0,1,0,0,0, ST_S,0,0,0, 2},   // R2 hop ignored in sleep
    '{0,0,0,0,0,0,0,1,0, ST_I,0,0,0, 10},  // R10
    '{0,0,0,0,0,0,0,1,0, ST_I,0,0,0, 10}   // R10 no effect outside sleep
  };

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearIn;
    softRst = 0; modeBidir = 0; txPin = 0; rxPin = 0; txBit = 0; rxBit = 0;
    burstStop = 0; hopSet = 0; pdWrite = 0; pdValue = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0;
    clearIn();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset state", {24'd0, obsV}, {24'd0, ST_I, 3'b000});
    chk("R1 reset clocks", {30'd0, refClkEn, modemEn | synthLocked}, 32'd2);
    @(posedge clk); #1;
    chk("R1 clkOut runs in reset", {31'd0, clkOut}, 32'd1);
    @(negedge clk);
    rstN = 1;
    step();

    for (int i = 0; i < NV; i++) begin
      modeBidir = VEC[i].mode; txPin = VEC[i].txP; rxPin = VEC[i].rxP;
      txBit = VEC[i].txB; rxBit = VEC[i].rxB; hopSet = VEC[i].hop;
      burstStop = VEC[i].stop; pdWrite = VEC[i].pdW; pdValue = VEC[i].pdV;
      step();
      chk($sformatf("R%0d row %0d", VEC[i].req, i), {24'd0, obsV},
          {24'd0, VEC[i].st, VEC[i].sy, VEC[i].tx, VEC[i].rx});
    end
    clearIn();
    step();

    // R3 lock count and restart
    hopSet = 1;
    step();
    hopSet = 0;
    chk("R3 unlocked at entry", {31'd0, synthLocked}, 32'd0);
    repeat (LOCK - 1) step();
    chk("R3 unlocked one edge early", {31'd0, synthLocked}, 32'd0);
    step();
    chk("R3 locked after count", {31'd0, synthLocked}, 32'd1);
    hopSet = 1;
    step();
    hopSet = 0;
    chk("R3 relock clears lock", {26'd0, stateOh, synthLocked}, {26'd0, ST_V, 1'b0});
    txPin = 1;
    step();
    chk("R4 tx modem on", {23'd0, obsV, modemEn}, {23'd0, ST_T, 3'b110, 1'b1});

    // R9 power down from a burst
    pdWrite = 1; pdValue = 1;
    step();
    pdWrite = 0; pdValue = 0;
    chk("R9 passes through idle", {23'd0, obsV, modemEn}, {23'd0, ST_I, 3'b000, 1'b0});
    step();
    txPin = 0;
    chk("R9 then sleep", {26'd0, stateOh, refClkEn}, {26'd0, ST_S, 1'b0});
    @(posedge clk); #1;
    chk("R8 clkOut stopped in sleep", {31'd0, clkOut}, 32'd0);
    @(negedge clk);

    // R10 wake and oscillator settle
    pdWrite = 1; pdValue = 0;
    @(posedge clk); #1;
    chk("R10 osc on at wake", {26'd0, stateOh, refClkEn}, {26'd0, ST_I, 1'b1});
    chk("R10 clkOut low at wake", {31'd0, clkOut}, 32'd0);
    @(negedge clk);
    pdWrite = 0;
    for (int k = 1; k <= SETTLE; k++) begin
      @(posedge clk); #1;
      chk($sformatf("R10 clkOut held low edge %0d", k), {31'd0, clkOut}, 32'd0);
    end
    @(posedge clk); #1;
    chk("R10 clkOut resumes", {31'd0, clkOut}, 32'd1);
    @(negedge clk);

    // R2 hop ignored in a burst, R1 soft reset
    hopSet = 1;
    step();
    hopSet = 0; txPin = 1;
    step();
    hopSet = 1;
    step();
    hopSet = 0;
    chk("R2 hop ignored in tx", {24'd0, obsV}, {24'd0, ST_T, 3'b110});
    softRst = 1;
    step();
    softRst = 0; txPin = 0;
    chk("R1 soft reset", {23'd0, obsV, modemEn}, {23'd0, ST_I, 3'b000, 1'b0});
    step();

    // R5 same-cycle priority in register mode
    modeBidir = 1; hopSet = 1;
    step();
    hopSet = 0; txBit = 1; rxBit = 1;
    step();
    chk("R5 tx wins in bidir", {24'd0, obsV}, {24'd0, ST_T, 3'b110});
    burstStop = 1;
    step();
    clearIn();
    step();

    // R1 pin reset from a receive burst
    hopSet = 1;
    step();
    hopSet = 0; rxPin = 1;
    step();
    chk("R4 rx burst", {24'd0, obsV}, {24'd0, ST_R, 3'b101});
    rstN = 0;
    #1;
    chk("R1 pin reset", {24'd0, obsV}, {24'd0, ST_I, 3'b000});
    @(negedge clk);
    rstN = 1; rxPin = 0;
    step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule